// File: doc/BRIEF.md
# ADC Self-Test Window Checker

This block watches the stream of conversion results an ADC produces while it runs its built-in self-test algorithms. Each result arrives tagged with the algorithm that produced it and the step within that algorithm. Three self-test algorithms exist: a supply check of 3 steps, a resistive-capacitive check of 19 steps, and a capacitive check of 17 steps. A fourth tag marks an ordinary application conversion. When checking is switched on for the tagged algorithm, the result is compared against that algorithm's own lower and upper guard values. A result outside the window latches an error for that algorithm together with the offending data. For the two multi-step algorithms, the failing step number is latched as well.

Latched errors drive an interrupt line through a per-algorithm mask and also drive two fault lines. The supply error goes to the critical line and the other two go to the non-critical line. The three supply conversions must form an unbroken group. Any other result that arrives between the first and the last supply step is reported as a sequencing error. The results enter through a valid/ready stream. The producer holds its beat stable while `res_valid` is high and `res_ready` is low. A beat is taken on every clock edge where both are high. The checker never applies back-pressure outside reset, and each accepted beat is fully evaluated in the cycle that accepts it.

Top module: `adcwin_chk`

## Requirements
- R1: `res_ready` is low during reset and high in every cycle after it. Once reset ends, all error flags, steps, data, `seq_err`, `irq` and both fault lines read zero until a beat is accepted.
- R2: `res_alg` encodes 0 = supply, 1 = resistive-capacitive, 2 = capacitive and 3 = normal conversion. An algorithm whose bit in `chk_en` (bit index = code) is clear never sets its error, whatever its data.
- R3: An accepted beat of an enabled algorithm whose data is below that algorithm's lower threshold or above its upper threshold sets `err_flag[code]` at that clock edge. Data equal to either threshold is inside the window and sets nothing. Thresholds for code a sit at bits `[a*DW +: DW]` of `thr_lo` and `thr_hi`.
- R4: The setting beat's data is stored in `err_data[a*DW +: DW]`. For codes 1 and 2, its step is stored in `err_step[a*STW +: STW]`.
- R5: The supply algorithm never records a step: `err_step[0 +: STW]` stays zero.
- R6: Only the first violation is held. Further violations of the same algorithm leave its flag, step and data unchanged until a one-cycle pulse on `err_clr[code]` clears all three. A violation in the same cycle as the clear pulse is captured.
- R7: `irq` is high exactly when some `err_flag[a]` is set with `irq_mask[a]` set.
- R8: `fault_crit` is high when the supply error or `seq_err` is set. `fault_ncrit` is high when the resistive-capacitive or the capacitive error is set.
- R9: A supply beat with step 0 opens a supply group, and a supply beat with step 2 closes it. An accepted non-supply beat while a group is open sets `seq_err` and aborts the group. `seq_err` holds until a `seq_clr` pulse; a set in the same cycle wins.
- R10: Normal conversions (code 3) are never compared and leave every error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Result beat valid |
| res_ready | output | 1 | Checker can take a beat |
| res_alg | input | 2 | Algorithm code of the beat |
| res_step | input | STW | Step number within the algorithm |
| res_data | input | DW | Converted data |
| chk_en | input | 3 | Per-algorithm checking enable |
| irq_mask | input | 3 | Per-algorithm interrupt enable |
| thr_lo | input | 3*DW | Lower thresholds, one per algorithm |
| thr_hi | input | 3*DW | Upper thresholds, one per algorithm |
| err_clr | input | 3 | Per-algorithm error clear pulse |
| seq_clr | input | 1 | Sequencing error clear pulse |
| err_flag | output | 3 | Latched window errors |
| err_step | output | 3*STW | Step of the first failing beat |
| err_data | output | 3*DW | Data of the first failing beat |
| seq_err | output | 1 | Supply group was interrupted |
| irq | output | 1 | Masked error interrupt |
| fault_crit | output | 1 | Critical fault line |
| fault_ncrit | output | 1 | Non-critical fault line |

## Verification
The window comparison is driven with data placed exactly on each threshold, one code beyond it, and at random. This separates an inclusive window from an exclusive or off-by-one one. Repeated violations with and without clear pulses show whether the first capture is held or overwritten. Enable bits, masks and thresholds are reshuffled between phases. Disabled algorithms and normal conversions carrying out-of-window data show that no comparison leaks across codes. Supply groups are sent both unbroken and cut by other beats, which separates correct group tracking from a checker that flags every interleave or none.

// File: rtl/adcwin_pkg.sv
package adcwin_pkg;
  localparam int NALG      = 3;
  localparam int SUP_STEPS = 3;
  localparam int RC_STEPS  = 19;
  localparam int CAP_STEPS = 17;
  localparam int MAX_STEPS = (RC_STEPS > CAP_STEPS) ? RC_STEPS : CAP_STEPS;
  localparam int STEP_W    = $clog2(MAX_STEPS);

  typedef enum logic [1:0] {
    ALG_SUP  = 2'd0,
    ALG_RC   = 2'd1,
    ALG_CAP  = 2'd2,
    ALG_NORM = 2'd3
  } alg_e;
endpackage

// File: rtl/adcwin_win.sv
module adcwin_win #(
  parameter int DW = 12
) (
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic          outside
);
  // Inclusive window: a value equal to a bound is inside.
  always_comb begin
    outside = (data < lo) || (data > hi);
  end
endmodule

// File: rtl/adcwin_rec.sv
module adcwin_rec #(
  parameter int DW        = 12,
  parameter int STW       = 5,
  parameter bit KEEP_STEP = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit,
  input  logic           clr,
  input  logic [STW-1:0] step_in,
  input  logic [DW-1:0]  data_in,
  output logic           flag,
  output logic [STW-1:0] step_q,
  output logic [DW-1:0]  data_q
);
  logic can_take;
  assign can_take = !flag || clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      data_q <= '0;
    end else if (hit && can_take) begin
      flag   <= 1'b1;
      data_q <= data_in;
    end else if (clr) begin
      flag   <= 1'b0;
      data_q <= '0;
    end
  end

  generate
    if (KEEP_STEP) begin : g_step
      always_ff @(posedge clk) begin
        if (!rst_n)               step_q <= '0;
        else if (hit && can_take) step_q <= step_in;
        else if (clr)             step_q <= '0;
      end
    end else begin : g_nostep
      assign step_q = '0;
    end
  endgenerate

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> (flag && $stable(data_q) && $stable(step_q)));
endmodule

// File: rtl/adcwin_seq.sv
module adcwin_seq #(
  parameter int STW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc,
  input  logic [1:0]     alg,
  input  logic [STW-1:0] step,
  input  logic           clr,
  output logic           seq_err
);
  import adcwin_pkg::*;
  localparam logic [STW-1:0] LAST = STW'(SUP_STEPS - 1);

  logic open_q;
  logic is_sup;
  logic breach;

  assign is_sup = (alg == ALG_SUP);
  assign breach = acc && !is_sup && open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      seq_err <= 1'b0;
    end else begin
      if (acc) begin
        if (!is_sup)            open_q <= 1'b0;
        else if (step == '0)    open_q <= 1'b1;
        else if (step == LAST)  open_q <= 1'b0;
      end
      seq_err <= (seq_err && !clr) || breach;
    end
  end

  // R9
  seq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> ($past(acc) && ($past(alg) != ALG_SUP)));
endmodule

// File: rtl/adcwin_chk.sv
module adcwin_chk #(
  parameter int DW  = 12,
  parameter int STW = adcwin_pkg::STEP_W
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               res_valid,
  output logic                               res_ready,
  input  logic [1:0]                         res_alg,
  input  logic [STW-1:0]                     res_step,
  input  logic [DW-1:0]                      res_data,
  input  logic [adcwin_pkg::NALG-1:0]        chk_en,
  input  logic [adcwin_pkg::NALG-1:0]        irq_mask,
  input  logic [adcwin_pkg::NALG*DW-1:0]     thr_lo,
  input  logic [adcwin_pkg::NALG*DW-1:0]     thr_hi,
  input  logic [adcwin_pkg::NALG-1:0]        err_clr,
  input  logic                               seq_clr,
  output logic [adcwin_pkg::NALG-1:0]        err_flag,
  output logic [adcwin_pkg::NALG*STW-1:0]    err_step,
  output logic [adcwin_pkg::NALG*DW-1:0]     err_data,
  output logic                               seq_err,
  output logic                               irq,
  output logic                               fault_crit,
  output logic                               fault_ncrit
);
  import adcwin_pkg::*;

  logic acc;

  always_ff @(posedge clk) begin
    if (!rst_n) res_ready <= 1'b0;
    else        res_ready <= 1'b1;
  end

  assign acc = res_valid && res_ready;

  generate
    for (genvar a = 0; a < NALG; a++) begin : g_alg
      localparam logic [1:0] CODE = 2'(a);
      logic outside;
      logic hit;

      adcwin_win #(.DW(DW)) u_win (
        .data    (res_data),
        .lo      (thr_lo[a*DW +: DW]),
        .hi      (thr_hi[a*DW +: DW]),
        .outside (outside)
      );

      assign hit = acc && (res_alg == CODE) && chk_en[a] && outside;

      adcwin_rec #(.DW(DW), .STW(STW), .KEEP_STEP(a != int'(ALG_SUP))) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr     (err_clr[a]),
        .step_in (res_step),
        .data_in (res_data),
        .flag    (err_flag[a]),
        .step_q  (err_step[a*STW +: STW]),
        .data_q  (err_data[a*DW +: DW])
      );

      // R4
      capture_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag[a]) |->
          (($past(res_data) < $past(thr_lo[a*DW +: DW])) ||
           ($past(res_data) > $past(thr_hi[a*DW +: DW]))) &&
          (err_data[a*DW +: DW] == $past(res_data)));
    end
  endgenerate

  adcwin_seq #(.STW(STW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .alg     (res_alg),
    .step    (res_step),
    .clr     (seq_clr),
    .seq_err (seq_err)
  );

  always_comb begin
    irq         = |(err_flag & irq_mask);
    fault_crit  = err_flag[ALG_SUP] || seq_err;
    fault_ncrit = err_flag[ALG_RC] || err_flag[ALG_CAP];
  end

  // R1
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> res_ready);

  // R10
  normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_alg == ALG_NORM) && (err_clr == '0)) |=> $stable(err_flag));
endmodule

// File: tb/adcwin_chk_tb.sv
module adcwin_chk_tb;
  localparam int DW  = 12;
  localparam int STW = 5;
  localparam int NA  = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic res_valid = 0;
  logic res_ready;
  logic [1:0] res_alg = 0;
  logic [STW-1:0] res_step = 0;
  logic [DW-1:0] res_data = 0;
  logic [NA-1:0] chk_en = 0, irq_mask = 0, err_clr = 0;
  logic [NA*DW-1:0] thr_lo = 0, thr_hi = 0;
  logic seq_clr = 0;
  logic [NA-1:0] err_flag;
  logic [NA*STW-1:0] err_step;
  logic [NA*DW-1:0] err_data;
  logic seq_err, irq, fault_crit, fault_ncrit;

  int checks = 0, failures = 0;
  bit done = 0;

  bit m_err[NA];
  logic [DW-1:0] m_data[NA];
  logic [STW-1:0] m_step[NA];
  bit m_open, m_seq;

  always #5 clk = ~clk;

  adcwin_chk #(.DW(DW), .STW(STW)) u_dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_alg(res_alg), .res_step(res_step), .res_data(res_data),
    .chk_en(chk_en), .irq_mask(irq_mask), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .err_clr(err_clr), .seq_clr(seq_clr), .err_flag(err_flag),
    .err_step(err_step), .err_data(err_data), .seq_err(seq_err), .irq(irq),
    .fault_crit(fault_crit), .fault_ncrit(fault_ncrit));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit outside(int a, logic [DW-1:0] d);
    return (d < thr_lo[a*DW +: DW]) || (d > thr_hi[a*DW +: DW]);
  endfunction

  function automatic bit exp_irq();
    bit r = 0;
    for (int a = 0; a < NA; a++) r |= m_err[a] & irq_mask[a];
    return r;
  endfunction

  task automatic check_all();
    chk(res_ready == 1'b1, "R1", "ready", int'(res_ready), 1);
    for (int a = 0; a < NA; a++) begin
      chk(err_flag[a] == m_err[a], "R3", $sformatf("flag%0d", a), int'(err_flag[a]), int'(m_err[a]));
      chk(err_data[a*DW +: DW] == m_data[a], "R4", $sformatf("data%0d", a),
          int'(err_data[a*DW +: DW]), int'(m_data[a]));
      chk(err_step[a*STW +: STW] == m_step[a], (a == 0) ? "R5" : "R4", $sformatf("step%0d", a),
          int'(err_step[a*STW +: STW]), int'(m_step[a]));
    end
    chk(irq == exp_irq(), "R7", "irq", int'(irq), int'(exp_irq()));
    chk(fault_crit == (m_err[0] | m_seq), "R8", "fault_crit", int'(fault_crit), int'(m_err[0] | m_seq));
    chk(fault_ncrit == (m_err[1] | m_err[2]), "R8", "fault_ncrit", int'(fault_ncrit), int'(m_err[1] | m_err[2]));
    chk(seq_err == m_seq, "R9", "seq_err", int'(seq_err), int'(m_seq));
  endtask

  // Drive one cycle, advance the reference model, check after the edge.
  task automatic cyc(bit v, int alg, int step, int data, logic [NA-1:0] clr, bit sclr);
    bit set;
    res_valid = v; res_alg = 2'(alg); res_step = STW'(step); res_data = DW'(data);
    err_clr = clr; seq_clr = sclr;
    for (int a = 0; a < NA; a++) begin
      bit hit, can;
      hit = v && (alg == a) && chk_en[a] && outside(a, DW'(data));
      can = !m_err[a] || clr[a];
      if (clr[a]) begin m_err[a] = 0; m_data[a] = 0; m_step[a] = 0; end
      if (hit && can) begin
        m_err[a] = 1; m_data[a] = DW'(data);
        m_step[a] = (a == 0) ? '0 : STW'(step);
      end
    end
    set = v && (alg != 0) && m_open;
    if (v) begin
      if (alg != 0) m_open = 0;
      else if (step == 0) m_open = 1;
      else if (step == 2) m_open = 0;
    end
    m_seq = (m_seq && !sclr) || set;
    @(posedge clk);
    @(negedge clk);
    res_valid = 0; err_clr = 0; seq_clr = 0;
    check_all();
  endtask

  task automatic set_thr(int a, int lo, int hi);
    thr_lo[a*DW +: DW] = DW'(lo);
    thr_hi[a*DW +: DW] = DW'(hi);
  endtask

  function automatic int pick_data(int a);
    int lo = int'(thr_lo[a*DW +: DW]);
    int hi = int'(thr_hi[a*DW +: DW]);
    case ($urandom % 5)
      0: return lo;
      1: return hi;
      2: return (lo > 0) ? lo - 1 : 0;
      3: return (hi < 4095) ? hi + 1 : 4095;
      default: return int'($urandom % 4096);
    endcase
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int sd;
    sd = $urandom(32'd1234);
    for (int a = 0; a < NA; a++) begin m_err[a] = 0; m_data[a] = 0; m_step[a] = 0; end
    m_open = 0; m_seq = 0;
    repeat (3) @(negedge clk);
    chk(res_ready == 1'b0, "R1", "ready in reset", int'(res_ready), 0);
    rst_n = 1;
    @(negedge clk);
    check_all();

    chk_en = 3'b111; irq_mask = 3'b111;
    set_thr(0, 10, 3000); set_thr(1, 100, 200); set_thr(2, 500, 600);
    // R3 boundaries inside
    cyc(1, 1, 3, 100, 0, 0);
    cyc(1, 1, 4, 200, 0, 0);
    chk(err_flag[1] == 0, "R3", "equal bounds inside", int'(err_flag[1]), 0);
    cyc(1, 1, 7, 201, 0, 0);
    chk(err_flag[1] && err_step[STW +: STW] == 7, "R4", "rc step captured",
        int'(err_step[STW +: STW]), 7);
    // R6 later violation ignored
    cyc(1, 1, 9, 50, 0, 0);
    chk(err_data[DW +: DW] == 201, "R6", "first data held", int'(err_data[DW +: DW]), 201);
    cyc(0, 0, 0, 0, 3'b010, 0);
    chk(err_flag[1] == 0, "R6", "cleared", int'(err_flag[1]), 0);
    // R5 supply step not kept
    cyc(1, 0, 2, 5, 0, 0);
    chk(err_step[0 +: STW] == 0 && fault_crit, "R5", "supply step zero", int'(err_step[0 +: STW]), 0);
    cyc(0, 0, 0, 0, 3'b001, 0);
    // R2 disabled
    chk_en = 3'b011;
    cyc(1, 2, 4, 4000, 0, 0);
    chk(err_flag[2] == 0, "R2", "disabled cap", int'(err_flag[2]), 0);
    chk_en = 3'b111;
    // R10 normal conversion
    cyc(1, 3, 0, 4095, 0, 0);
    chk(err_flag == 0, "R10", "normal ignored", int'(err_flag), 0);
    // R9 interrupted supply group
    cyc(1, 0, 0, 100, 0, 0);
    cyc(1, 3, 0, 100, 0, 0);
    chk(seq_err == 1, "R9", "interleave flagged", int'(seq_err), 1);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(1, 0, 0, 100, 0, 0);
    cyc(1, 0, 1, 100, 0, 0);
    cyc(1, 0, 2, 100, 0, 0);
    cyc(1, 3, 0, 100, 0, 0);
    chk(seq_err == 0, "R9", "whole group clean", int'(seq_err), 0);

    for (int ph = 0; ph < 8; ph++) begin
      for (int a = 0; a < NA; a++) begin
        int x = int'($urandom % 4096), y = int'($urandom % 4096);
        if (x <= y) set_thr(a, x, y); else set_thr(a, y, x);
      end
      chk_en = 3'($urandom); irq_mask = 3'($urandom);
      for (int i = 0; i < 60; i++) begin
        int alg = int'($urandom % 4);
        int st;
        logic [NA-1:0] clr;
        clr = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
        if (alg == 0) begin
          for (int s = 0; s < 3; s++) begin
            if (($urandom % 6) == 0) cyc(1, 3, 0, pick_data(0), 0, 0);
            cyc(1, 0, s, pick_data(0), 0, 0);
          end
        end else begin
          st = (alg == 1) ? int'($urandom % 19) : (alg == 2) ? int'($urandom % 17) : 0;
          cyc(($urandom % 4) != 0, alg, st, pick_data((alg == 3) ? 0 : alg), clr,
              ($urandom % 10) == 0);
        end
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule